// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds eight binary ownership tokens shared by two independent processor ports, called left and right. Software on either side claims a token for some shared resource by writing to a flag, then reads the flag back to learn whether the claim succeeded. The flags are kept apart from any memory storage. They only advise: no hardware path lets a flag stall or block either port.

Each flag records which side holds it, and a read tells a port only whether *that port* holds the token. Flags are active low: a port writes 0 to claim a flag and writes 1 to give it back. Only the holder can give a flag back. A claim that loses is dropped and is not queued, so the losing side has to claim again later. Writes take effect at the clock edge. Reads are combinational from the registered flag state, so an access never adds a wait state.

Top module: `sem_latch_bank`

## Requirements
- R1: After reset all eight flags are free, and a read of any index returns all ones on both ports.
- R2: A write (sem_en=1, we=1) with data bit 0 = 0 to a free flag gives that port ownership from the next clock edge. From then on that port's read of the index returns all zeros.
- R3: A port that does not own a flag reads all ones at that index, whether the flag is free or held by the other side.
- R4: When both ports write 0 to the same free flag in the same cycle, the left port becomes the owner and the right request is dropped.
- R5: A write of 0 from the non-owner is discarded and not queued. Once the owner releases the flag, it stays free.
- R6: A write of 1 from the owner frees the flag. A write of 1 from the non-owner, or to a free flag, changes nothing.
- R7: Writes decode only data bit 0. Every other data bit is ignored.
- R8: A write with sem_en=0 does not change any flag.
- R9: Each of the eight flags is independent. An access to one index leaves every other index unchanged, and the two ports may hold different flags at the same time.
- R10: Read data is the port's flag value copied onto every data bit. It appears in the same cycle as sem_en=1, oe=1 and we=0. In every other case read data is all zeros.

Each read is valid in the cycle it is presented, with no wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| l_sem_en_i | input | 1 | Left semaphore access enable |
| l_we_i | input | 1 | Left write strobe |
| l_oe_i | input | 1 | Left output enable |
| l_idx_i | input | 3 | Left flag index |
| l_wdata_i | input | DATA_W | Left write data (bit 0 used) |
| l_rdata_o | output | DATA_W | Left read data |
| r_sem_en_i | input | 1 | Right semaphore access enable |
| r_we_i | input | 1 | Right write strobe |
| r_oe_i | input | 1 | Right output enable |
| r_idx_i | input | 3 | Right flag index |
| r_wdata_i | input | DATA_W | Right write data (bit 0 used) |
| r_rdata_o | output | DATA_W | Right read data |

## Verification
The hardest cases to reach are the ones where both ports act on one flag in the same cycle. These include two claims on a free flag, and the owner releasing while the other side claims. Neither case occurs unless the two ports' stimulus is lined up to the same edge. Directed sequences set up each collision on purpose. A long random phase then draws both ports' indices from a narrow range, so that collisions and foreign writes come up often, and a behavioural owner model is compared on every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 sem_en_i,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [NUM_FLAGS-1:0] req_o,
  output logic [NUM_FLAGS-1:0] rel_o
);
  logic                 wr_act;
  logic [NUM_FLAGS-1:0] sel;
  logic                 unused_wdata_hi;

  assign wr_act          = sem_en_i & we_i;
  assign sel             = NUM_FLAGS'(1) << idx_i;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:1];

  always_comb begin
    req_o = '0;
    rel_o = '0;
    if (wr_act) begin
      if (wdata_i[0]) rel_o = sel;
      else            req_o = sel;
    end
  end

  // R7 / R8: at most one flag targeted, and no decode without an enabled write
  always_comb begin
    assert ($onehot0(req_o | rel_o)) else $error("p_single_target_r9");
    if (!wr_act) assert ((req_o | rel_o) == '0) else $error("p_no_decode_idle_r8");
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_req_i,
  input  logic l_rel_i,
  input  logic r_req_i,
  input  logic r_rel_i,
  output logic own_l_o,
  output logic own_r_o
);
  owner_e owner_q, owner_d;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (l_req_i)      owner_d = OWN_LEFT;   // left takes priority
        else if (r_req_i) owner_d = OWN_RIGHT;
      end
      OWN_LEFT:  if (l_rel_i) owner_d = OWN_NONE;
      OWN_RIGHT: if (r_rel_i) owner_d = OWN_NONE;
      default:   owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_d;
  end

  assign own_l_o = (owner_q == OWN_LEFT);
  assign own_r_o = (owner_q == OWN_RIGHT);

  p_excl_owner_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(own_l_o && own_r_o));
  p_left_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && l_req_i && r_req_i) |=> own_l_o);
  p_take_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && r_req_i && !l_req_i) |=> own_r_o);
  p_keep_left_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l_o && !l_rel_i) |=> own_l_o);
  p_keep_right_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_r_o && !r_rel_i) |=> own_r_o);
  p_no_queue_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l_o && l_rel_i) |=> !own_l_o && !own_r_o);
endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 sem_en_i,
  input  logic                 we_i,
  input  logic                 oe_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_FLAGS-1:0] own_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic rd_act;
  logic flag_bit;

  assign rd_act   = sem_en_i & oe_i & ~we_i;
  assign flag_bit = ~own_i[idx_i];  // active low: 0 means held by this port
  assign rdata_o  = rd_act ? {DATA_W{flag_bit}} : '0;

  always_comb begin
    if (!rd_act) assert (rdata_o == '0) else $error("p_idle_zero_r10");
    assert (rdata_o == '0 || rdata_o == '1) else $error("p_replicated_r10");
  end
endmodule

// File: rtl/sem_latch_bank.sv
module sem_latch_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sem_en_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [IDX_W-1:0]  l_idx_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_sem_en_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [IDX_W-1:0]  r_idx_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_FLAGS-1:0] own_l, own_r;

  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_l (
    .sem_en_i(l_sem_en_i), .we_i(l_we_i), .idx_i(l_idx_i), .wdata_i(l_wdata_i),
    .req_o(l_req), .rel_o(l_rel)
  );
  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_r (
    .sem_en_i(r_sem_en_i), .we_i(r_we_i), .idx_i(r_idx_i), .wdata_i(r_wdata_i),
    .req_o(r_req), .rel_o(r_rel)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .l_req_i(l_req[g]), .l_rel_i(l_rel[g]),
      .r_req_i(r_req[g]), .r_rel_i(r_rel[g]),
      .own_l_o(own_l[g]), .own_r_o(own_r[g])
    );
  end

  sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
    .sem_en_i(l_sem_en_i), .we_i(l_we_i), .oe_i(l_oe_i), .idx_i(l_idx_i),
    .own_i(own_l), .rdata_o(l_rdata_o)
  );
  sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
    .sem_en_i(r_sem_en_i), .we_i(r_we_i), .oe_i(r_oe_i), .idx_i(r_idx_i),
    .own_i(own_r), .rdata_o(r_rdata_o)
  );

  p_reset_free_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (own_l == '0 && own_r == '0));
  p_disabled_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_sem_en_i && !r_sem_en_i) |=> ($stable(own_l) && $stable(own_r)));
endmodule

// File: tb/sem_latch_bank_tb_top.sv
module sem_latch_bank_tb_top;
  localparam int NF = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_we = 0, l_oe = 0, r_en = 0, r_we = 0, r_oe = 0;
  logic [2:0] l_idx = '0, r_idx = '0;
  logic [DW-1:0] l_wd = '0, r_wd = '0;
  logic [DW-1:0] l_rd, r_rd;

  int checks = 0, fails = 0;
  int own [NF];  // 0 free, 1 left, 2 right
  bit done = 0;

  always #10 clk = ~clk;

  sem_latch_bank #(.NUM_FLAGS(NF), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sem_en_i(l_en), .l_we_i(l_we), .l_oe_i(l_oe), .l_idx_i(l_idx),
    .l_wdata_i(l_wd), .l_rdata_o(l_rd),
    .r_sem_en_i(r_en), .r_we_i(r_we), .r_oe_i(r_oe), .r_idx_i(r_idx),
    .r_wdata_i(r_wd), .r_rdata_o(r_rd)
  );

  function automatic logic [DW-1:0] exp_rd(bit en, bit we, bit oe, int idx, int me);
    if (!(en && oe && !we)) return '0;
    return (own[idx] == me) ? '0 : '1;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_l(bit en, bit we, bit oe, int idx, logic [DW-1:0] d);
    l_en = en; l_we = we; l_oe = oe; l_idx = 3'(idx); l_wd = d;
  endtask
  task automatic drive_r(bit en, bit we, bit oe, int idx, logic [DW-1:0] d);
    r_en = en; r_we = we; r_oe = oe; r_idx = 3'(idx); r_wd = d;
  endtask

  // compare both read ports, then advance model and DUT one edge
  task automatic step(string tag);
    int cur [NF];
    #1;
    chk({tag, " L"}, l_rd, exp_rd(l_en, l_we, l_oe, int'(l_idx), 1));
    chk({tag, " R"}, r_rd, exp_rd(r_en, r_we, r_oe, int'(r_idx), 2));
    @(posedge clk);
    foreach (own[i]) cur[i] = own[i];
    for (int i = 0; i < NF; i++) begin
      bit lq = l_en && l_we && int'(l_idx) == i && !l_wd[0];
      bit lr = l_en && l_we && int'(l_idx) == i &&  l_wd[0];
      bit rq = r_en && r_we && int'(r_idx) == i && !r_wd[0];
      bit rr = r_en && r_we && int'(r_idx) == i &&  r_wd[0];
      if (cur[i] == 0)      own[i] = lq ? 1 : (rq ? 2 : 0);
      else if (cur[i] == 1) own[i] = lr ? 0 : 1;
      else                  own[i] = rr ? 0 : 2;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    drive_l(0, 0, 0, 0, '0);
    drive_r(0, 0, 0, 0, '0);
  endtask

  task automatic rd_both(string tag, int li, int ri);
    drive_l(1, 0, 1, li, '0);
    drive_r(1, 0, 1, ri, '0);
    step(tag);
  endtask

  initial begin : watchdog
    #(20 * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (own[i]) own[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state on every index
    for (int i = 0; i < NF; i++) rd_both("R1 reset free", i, NF - 1 - i);

    // R2 / R3: left claims flag 3
    drive_l(1, 1, 0, 3, 16'h0000); drive_r(0, 0, 0, 0, '0); step("R2 claim");
    rd_both("R2 owner reads 0 / R3 other reads 1", 3, 3);
    rd_both("R3 free flag reads 1", 4, 4);

    // R5: right claim while held, then left releases: no queued grant
    drive_l(0, 0, 0, 0, '0); drive_r(1, 1, 0, 3, 16'h0000); step("R5 foreign claim");
    drive_l(1, 1, 0, 3, 16'h0001); drive_r(0, 0, 0, 0, '0); step("R5 release");
    rd_both("R5 not queued", 3, 3);

    // R5 corner: release and foreign claim in same cycle
    drive_l(1, 1, 0, 2, '0); idle_r(); step("R5 setup");
    drive_l(1, 1, 0, 2, 16'h0001); drive_r(1, 1, 0, 2, '0); step("R5 same cycle");
    rd_both("R5 same cycle result", 2, 2);

    // R4: simultaneous claim of free flag 5
    drive_l(1, 1, 0, 5, '0); drive_r(1, 1, 0, 5, '0); step("R4 collide");
    rd_both("R4 left wins", 5, 5);

    // R6: foreign release and release of free flag have no effect
    drive_l(0, 0, 0, 0, '0); drive_r(1, 1, 0, 5, 16'h0001); step("R6 foreign rel");
    drive_l(1, 1, 0, 6, 16'h0001); drive_r(0, 0, 0, 0, '0); step("R6 free rel");
    rd_both("R6 still held", 5, 5);
    rd_both("R6 free stays free", 6, 6);

    // R7: only bit 0 decoded
    drive_l(0, 0, 0, 0, '0); drive_r(1, 1, 0, 1, 16'hFFFE); step("R7 claim hi bits set");
    rd_both("R7 claim taken", 1, 1);
    drive_l(0, 0, 0, 0, '0); drive_r(1, 1, 0, 1, 16'h8000); step("R7 bit0 zero not release");
    rd_both("R7 still held", 1, 1);
    drive_l(0, 0, 0, 0, '0); drive_r(1, 1, 0, 1, 16'h0001); step("R7 release");
    rd_both("R7 released", 1, 1);

    // R8: disabled writes ignored
    drive_l(0, 1, 0, 0, '0); drive_r(0, 1, 0, 7, '0); step("R8 disabled");
    rd_both("R8 no claim", 0, 7);
    drive_l(0, 1, 0, 5, 16'h0001); idle_r(); step("R8 disabled release");
    rd_both("R8 still held", 5, 5);

    // R9: ports hold different flags at once
    drive_l(1, 1, 0, 0, '0); drive_r(1, 1, 0, 7, '0); step("R9 dual claim");
    for (int i = 0; i < NF; i++) rd_both("R9 per-index", i, i);

    // R10: no read when oe low, we high or sem_en low
    drive_l(1, 0, 0, 0, '0); drive_r(1, 0, 0, 7, '0); step("R10 oe low");
    drive_l(0, 0, 1, 0, '0); drive_r(0, 0, 1, 7, '0); step("R10 en low");
    drive_l(1, 1, 1, 4, 16'h0001); drive_r(1, 1, 1, 4, 16'h0001); step("R10 we high");

    // random phase, narrow index range for collisions (R4 R5 R6 R9)
    for (int n = 0; n < 2000; n++) begin
      drive_l(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)),
              DW'($urandom));
      drive_r(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)),
              DW'($urandom));
      step("R9 random");
    end

    idle(); step("idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic idle_r();
    drive_r(0, 0, 0, 0, '0);
  endtask
endmodule